// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is the master side of an 8-bit parallel configuration port for a target FPGA. Once it receives a start pulse and a total byte count, it runs the full bring-up sequence. It pulses the program line low, waits for the target to acknowledge by pulling its init line low, and releases the program line. It then waits for init to return high with busy low, selects the target for writing, and waits a setup interval. After that it streams the bytes one configuration-clock pulse at a time and finally checks for the done indication.

Bytes arrive on a valid/ready stream. The block latches a byte only in the data phase and asserts ready for a single cycle at the end of each clock pulse. Every wait has its own timeout, measured in system-clock cycles. A failure releases the select and write strobes, records a sticky failure code and returns the block to idle. A successful run sets a sticky pass flag. The next accepted start clears both.

Top module: `par_cfg_loader`

## Requirements
- R1: After reset, prog_n_o, cs_n_o, write_n_o and cclk_o are high, and byte_ready_o, run_o, pass_o and fail_code_o (value 0) are low.
- R2: On an accepted start, prog_n_o stays low for at least PROG_LOW_CYC cycles and until init_n_i has been seen low. If init_n_i is not low within INIT_ASSERT_TMO cycles, prog_n_o rises after exactly INIT_ASSERT_TMO cycles and fail_code_o becomes 1.
- R3: After prog_n_o rises, cclk_o is high and the block waits for init_n_i high with busy_i low. If that does not happen within INIT_RELEASE_TMO cycles, it fails with code 2 and cs_n_o never goes low.
- R4: cs_n_o and write_n_o fall in the same cycle. When a byte is already valid, the first cclk_o falling edge comes exactly SETUP_CYC+1 cycles after cs_n_o falls.
- R5: Each byte is latched from byte_data_i, held on data_o while cclk_o is low, and clocked with cclk_o low for CCLK_HALF cycles and then high for CCLK_HALF cycles. byte_ready_o is high for exactly one cycle at the end of each pulse. Exactly total_bytes_i pulses are made, in stream order.
- R6: init_n_i is checked before every byte. If it is low in the data phase, the block fails with code 3 and makes no further cclk_o pulse.
- R7: With CHECK_BUSY set, the block waits after every pulse until busy_i is low. If busy_i stays high for BUSY_TMO cycles, it fails with code 4.
- R8: After the last byte, cs_n_o rises exactly one cycle before write_n_o.
- R9: pass_o is set only when done_i and init_n_i are both high after the stream. If that does not happen within DONE_TMO cycles, the block fails with code 5.
- R10: On any failure, cs_n_o and write_n_o rise in the same cycle and run_o falls. fail_code_o holds its value in idle until the next accepted start, which clears it and pass_o.
- R11: start_i is ignored while run_o is high; a run produces exactly one program pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| total_bytes_i | input | CNT_W | Number of bytes to stream, sampled at start |
| byte_data_i | input | 8 | Stream data byte |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_ready_o | output | 1 | One-cycle pulse when a byte has been clocked out |
| init_n_i | input | 1 | Target init line (low = clearing or error) |
| busy_i | input | 1 | Target busy line |
| done_i | input | 1 | Target done line |
| prog_n_o | output | 1 | Target program line, active low |
| cs_n_o | output | 1 | Target chip select, active low |
| write_n_o | output | 1 | Target write strobe, active low |
| cclk_o | output | 1 | Configuration clock; target captures on its rise |
| data_o | output | 8 | Configuration data byte |
| run_o | output | 1 | High while a sequence is in progress |
| pass_o | output | 1 | Sticky success flag |
| fail_code_o | output | 3 | Sticky failure code: 0 none, 1 init-assert timeout, 2 init-release timeout, 3 CRC error, 4 busy timeout, 5 done timeout |

## Verification
The hardest case to reach from the ports is a CRC failure in the middle of the stream. The target must drop init only after a chosen number of bytes have been clocked in, and the drop must be timed against the pulse that follows. The bench drives a behavioural target that counts captured bytes on cclk_o rising edges and pulls init low right after byte k. It then checks that exactly k pulses occurred and that both strobes were released together. Each timeout is reached by holding one target line fixed, and the resulting program-pulse width is compared with the exact timeout.

// File: rtl/par_cfg_pkg.sv
package par_cfg_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_INITW, S_SETUP, S_DATA,
    S_CLO, S_CHI, S_BUSYW, S_CLOSE, S_DONEW
  } ld_state_e;

  typedef enum logic [2:0] {
    F_NONE     = 3'd0,
    F_INIT_AS  = 3'd1,
    F_INIT_REL = 3'd2,
    F_CRC      = 3'd3,
    F_BUSY     = 3'd4,
    F_DONE     = 3'd5
  } ld_fail_e;

  // true in the last cycle of a dwell of lim cycles counted from zero
  function automatic logic at_limit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1 >= lim);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_dwell_timer.sv
module cfg_dwell_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count_o <= '0;
    else if (restart_i)         count_o <= '0;
    else if (count_o != '1)     count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/cfg_byte_tally.sv
module cfg_byte_tally #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] total_i,
  input  logic         dec_i,
  output logic         zero_o,
  output logic         last_o
);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rem_q <= '0;
    else if (load_i)              rem_q <= total_i;
    else if (dec_i && rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  assign zero_o = (rem_q == '0);
  assign last_o = (rem_q == W'(1));
endmodule

// File: rtl/par_cfg_loader.sv
module par_cfg_loader
  import par_cfg_pkg::*;
#(
  parameter int unsigned PROG_LOW_CYC     = 32,
  parameter int unsigned INIT_ASSERT_TMO  = 50_000_000,
  parameter int unsigned INIT_RELEASE_TMO = 50_000_000,
  parameter int unsigned SETUP_CYC        = 1_000_000,
  parameter int unsigned BUSY_TMO         = 500_000,
  parameter int unsigned DONE_TMO         = 20_000_000,
  parameter int unsigned CCLK_HALF        = 2,
  parameter bit          CHECK_BUSY       = 1'b1,
  parameter int          CNT_W            = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] total_bytes_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic             init_n_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             prog_n_o,
  output logic             cs_n_o,
  output logic             write_n_o,
  output logic             cclk_o,
  output logic [7:0]       data_o,
  output logic             run_o,
  output logic             pass_o,
  output logic [2:0]       fail_code_o
);
  localparam int unsigned TMAX = max2(max2(max2(PROG_LOW_CYC, INIT_ASSERT_TMO),
                                           max2(INIT_RELEASE_TMO, SETUP_CYC)),
                                      max2(max2(BUSY_TMO, DONE_TMO), CCLK_HALF));
  localparam int TW = $clog2(TMAX + 1) + 1;

  ld_state_e   st_q, st_d;
  ld_fail_e    abort_c;
  logic        fin_ok;
  logic [TW-1:0] t_q;
  logic        rem_zero, rem_last;

  // named internal events
  logic accept_start, new_state, take_byte, ready_pulse, abort_ev;
  int unsigned t_i;

  assign t_i          = int'(t_q);
  assign accept_start = (st_q == S_IDLE) && start_i;
  assign new_state    = (st_d != st_q);
  assign take_byte    = (st_q == S_DATA) && (st_d == S_CLO);
  assign ready_pulse  = (st_q == S_CHI) && at_limit(t_i, CCLK_HALF);
  assign abort_ev     = (abort_c != F_NONE);

  cfg_dwell_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart_i(new_state), .count_o(t_q)
  );

  cfg_byte_tally #(.W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .load_i(accept_start), .total_i(total_bytes_i),
    .dec_i(ready_pulse), .zero_o(rem_zero), .last_o(rem_last)
  );

  always_comb begin
    st_d    = st_q;
    abort_c = F_NONE;
    fin_ok  = 1'b0;
    unique case (st_q)
      S_IDLE:  if (start_i) st_d = S_PROG;
      S_PROG: begin
        if (at_limit(t_i, PROG_LOW_CYC) && !init_n_i) st_d = S_INITW;
        else if (at_limit(t_i, INIT_ASSERT_TMO))      abort_c = F_INIT_AS;
      end
      S_INITW: begin
        if (init_n_i && !busy_i)                    st_d = S_SETUP;
        else if (at_limit(t_i, INIT_RELEASE_TMO))   abort_c = F_INIT_REL;
      end
      S_SETUP: if (at_limit(t_i, SETUP_CYC)) st_d = rem_zero ? S_CLOSE : S_DATA;
      S_DATA: begin
        if (!init_n_i)         abort_c = F_CRC;
        else if (byte_valid_i) st_d = S_CLO;
      end
      S_CLO: if (at_limit(t_i, CCLK_HALF)) st_d = S_CHI;
      S_CHI: begin
        if (at_limit(t_i, CCLK_HALF)) begin
          if (CHECK_BUSY) st_d = S_BUSYW;
          else            st_d = rem_last ? S_CLOSE : S_DATA;
        end
      end
      S_BUSYW: begin
        if (!busy_i)                       st_d = rem_zero ? S_CLOSE : S_DATA;
        else if (at_limit(t_i, BUSY_TMO))  abort_c = F_BUSY;
      end
      S_CLOSE: st_d = S_DONEW;
      S_DONEW: begin
        if (done_i && init_n_i) begin
          fin_ok = 1'b1;
          st_d   = S_IDLE;
        end else if (at_limit(t_i, DONE_TMO)) abort_c = F_DONE;
      end
      default: st_d = S_IDLE;
    endcase
    if (abort_c != F_NONE) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      data_o      <= '0;
      pass_o      <= 1'b0;
      fail_code_o <= F_NONE;
    end else begin
      st_q <= st_d;
      if (take_byte) data_o <= byte_data_i;
      if (accept_start) begin
        pass_o      <= 1'b0;
        fail_code_o <= F_NONE;
      end else if (abort_ev) begin
        fail_code_o <= abort_c;
      end else if (fin_ok) begin
        pass_o <= 1'b1;
      end
    end
  end

  // pin decode from state
  assign prog_n_o     = (st_q != S_PROG);
  assign cs_n_o       = !(st_q inside {S_SETUP, S_DATA, S_CLO, S_CHI, S_BUSYW});
  assign write_n_o    = !(st_q inside {S_SETUP, S_DATA, S_CLO, S_CHI, S_BUSYW, S_CLOSE});
  assign cclk_o       = (st_q != S_CLO);
  assign byte_ready_o = ready_pulse;
  assign run_o        = (st_q != S_IDLE);

  // program-pulse width counter for the checks below
  logic [TW-1:0] plow_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         plow_q <= '0;
    else if (prog_n_o)                  plow_q <= '0;
    else if (plow_q != '1)              plow_q <= plow_q + 1'b1;
  end

  p_prog_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n_o) |-> (int'(plow_q) >= PROG_LOW_CYC));

  p_sel_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $fell(write_n_o));

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cclk_o && $past(!cclk_o)) |-> $stable(data_o));

  p_ready_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |=> !byte_ready_o);

  p_no_pulse_on_init_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk_o) |-> $past(init_n_i));

  p_cs_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_n_o) |-> cs_n_o);

  p_code_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !$past(run_o) && !$past(start_i)) |-> $stable(fail_code_o));

  p_one_prog_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && $past(run_o) && $past(st_q) != S_IDLE) |-> !(st_q == S_PROG && $past(st_q) != S_PROG));

endmodule

// File: tb/test_par_cfg_loader.sv
module test_par_cfg_loader;
  localparam int PL = 4, IAT = 20, IRT = 20, SET = 3, BT = 10, DT = 15, HALF = 2;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CW-1:0] total_bytes_i = '0;
  logic [7:0] byte_data_i = '0;
  logic byte_valid_i = 1'b0;
  logic byte_ready_o, init_n_i, busy_i, done_i;
  logic prog_n_o, cs_n_o, write_n_o, cclk_o, run_o, pass_o;
  logic [7:0] data_o;
  logic [2:0] fail_code_o;

  always #5 clk = ~clk;

  par_cfg_loader #(
    .PROG_LOW_CYC(PL), .INIT_ASSERT_TMO(IAT), .INIT_RELEASE_TMO(IRT),
    .SETUP_CYC(SET), .BUSY_TMO(BT), .DONE_TMO(DT), .CCLK_HALF(HALF),
    .CHECK_BUSY(1'b1), .CNT_W(CW)
  ) i_par_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_bytes_i(total_bytes_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .init_n_i(init_n_i), .busy_i(busy_i), .done_i(done_i),
    .prog_n_o(prog_n_o), .cs_n_o(cs_n_o), .write_n_o(write_n_o), .cclk_o(cclk_o),
    .data_o(data_o), .run_o(run_o), .pass_o(pass_o), .fail_code_o(fail_code_o)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // knobs for the behavioural target (255 means never)
  int k_total = 0, k_fall = 2, k_rise = 3, k_busy = 0, k_crc = 255, k_done = 2;
  bit k_gap = 0;

  // target state and statistics
  logic init_lo = 0, crc_hit = 0, busy_r = 0, done_r = 0;
  int pcnt = 0, rcnt = 0, bcnt = 0, dcnt = 0, cyc = 0;
  logic [7:0] cap [0:255];
  int ncap = 0, nready = 0, src_idx = 0, npulse = 0, ncsf = 0, nprogf = 0;
  int lw = 0, lw_min = 1000, lw_max = 0, plow_w = 0, last_plow = 0;
  int t_cs = 0, t_wr = 0, t_csf = 0, t_cf1 = -1;
  logic prev_cclk = 1, prev_cs = 1, prev_wr = 1, prev_prog = 1;

  assign init_n_i = ~init_lo;
  assign busy_i   = busy_r;
  assign done_i   = done_r;

  function automatic logic [7:0] src_byte(input int i, input int tot);
    return 8'((i * 37) + (tot * 11) + 5);
  endfunction

  // target model, stream source and monitors
  initial begin
    forever begin
      @(posedge clk);
      cyc       <= cyc + 1;
      prev_cclk <= cclk_o; prev_cs <= cs_n_o; prev_wr <= write_n_o; prev_prog <= prog_n_o;
      if (!prog_n_o) begin
        if (pcnt >= k_fall) init_lo <= 1'b1;
        pcnt <= pcnt + 1; rcnt <= 0; crc_hit <= 0; bcnt <= 0; busy_r <= 0;
        done_r <= 0; dcnt <= 0; plow_w <= plow_w + 1;
        if (prev_prog) nprogf <= nprogf + 1;
      end else begin
        pcnt <= 0;
        if (!prev_prog) begin last_plow <= plow_w; plow_w <= 0; end
        if (init_lo && !crc_hit) begin
          if (rcnt >= k_rise) init_lo <= 1'b0;
          rcnt <= rcnt + 1;
        end
        if (cclk_o && !prev_cclk && !cs_n_o && !write_n_o) begin
          cap[ncap[7:0]] <= data_o;
          ncap <= ncap + 1;
          if (k_busy > 0) begin busy_r <= 1'b1; bcnt <= k_busy; end
          if (ncap + 1 == k_crc) begin init_lo <= 1'b1; crc_hit <= 1'b1; end
        end else if (bcnt > 0) begin
          bcnt <= bcnt - 1;
          if (bcnt == 1) busy_r <= 1'b0;
        end
        if (ncap == k_total && cs_n_o && k_done < 255 && !crc_hit) begin
          if (dcnt >= k_done) done_r <= 1'b1;
          dcnt <= dcnt + 1;
        end
      end
      // configuration clock monitors
      if (!cclk_o) lw <= lw + 1;
      else if (!prev_cclk) begin
        if (lw < lw_min) lw_min <= lw;
        if (lw > lw_max) lw_max <= lw;
        lw <= 0;
      end
      if (!cclk_o && prev_cclk) begin
        npulse <= npulse + 1;
        if (t_cf1 < 0) t_cf1 <= cyc;
      end
      if (cs_n_o && !prev_cs) t_cs <= cyc;
      if (write_n_o && !prev_wr) t_wr <= cyc;
      if (!cs_n_o && prev_cs) begin ncsf <= ncsf + 1; t_csf <= cyc; end
      // stream source
      if (byte_ready_o) nready <= nready + 1;
      if (!(byte_valid_i && !byte_ready_o)) begin
        int nx;
        nx = src_idx + (byte_ready_o ? 1 : 0);
        src_idx      <= nx;
        byte_valid_i <= (nx < k_total) && !(k_gap && (cyc % 3 == 0));
        byte_data_i  <= src_byte(nx, k_total);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_run(input int tot, input int fall, input int rise, input int busy,
                        input int crc, input int dn, input bit gap, input bit mid);
    int guard;
    @(negedge clk);
    k_total = tot; k_fall = fall; k_rise = rise; k_busy = busy; k_crc = crc;
    k_done = dn; k_gap = gap;
    ncap = 0; nready = 0; src_idx = 0; npulse = 0; ncsf = 0; nprogf = 0;
    lw_min = 1000; lw_max = 0; last_plow = 0; t_cs = 0; t_wr = 0; t_csf = 0; t_cf1 = -1;
    byte_valid_i = 1'b0;
    total_bytes_i = CW'(tot);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (mid) begin
      repeat (30) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (run_o && guard < 3000) begin @(negedge clk); guard++; end
    chk(guard < 3000, "R9", "run finished (watchdog)", guard, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_success(input int tot, input bit gap);
    int bad;
    bad = 0;
    for (int i = 0; i < tot; i++) if (cap[i] != src_byte(i, tot)) bad++;
    chk(fail_code_o == 3'd0, "R9", "fail code", fail_code_o, 0);
    chk(pass_o == 1'b1, "R9", "pass flag", pass_o, 1);
    chk(ncap == tot, "R5", "bytes captured", ncap, tot);
    chk(bad == 0, "R5", "byte mismatches", bad, 0);
    chk(nready == tot, "R5", "ready pulses", nready, tot);
    chk(npulse == tot, "R5", "cclk pulses", npulse, tot);
    if (tot > 0) begin
      chk(lw_min == HALF, "R5", "cclk low min", lw_min, HALF);
      chk(lw_max == HALF, "R5", "cclk low max", lw_max, HALF);
      if (!gap) chk(t_cf1 - t_csf == SET + 1, "R4", "select to first cclk", t_cf1 - t_csf, SET + 1);
    end
    chk(t_wr - t_cs == 1, "R8", "write release after select", t_wr - t_cs, 1);
    chk(last_plow >= PL, "R2", "program pulse width min", last_plow, PL);
    chk(nprogf == 1, "R11", "program pulses", nprogf, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(prog_n_o && cs_n_o && write_n_o && cclk_o, "R1", "idle pins", {prog_n_o, cs_n_o, write_n_o, cclk_o}, 15);
    chk(!byte_ready_o && !run_o && !pass_o, "R1", "idle flags", {byte_ready_o, run_o, pass_o}, 0);
    chk(fail_code_o == 3'd0, "R1", "idle code", fail_code_o, 0);

    // near-exhaustive success sweep: R4 R5 R7 R8 R9
    for (int tot = 0; tot <= 5; tot++)
      for (int b = 0; b <= 2; b++)
        for (int g = 0; g <= 1; g++) begin
          do_run(tot, 2, 3, b, 255, 2, g[0], 1'b0);
          chk_success(tot, g[0]);
        end

    // R2 immediate init response still honours minimum pulse
    do_run(3, 0, 1, 0, 255, 0, 1'b0, 1'b0);
    chk_success(3, 1'b0);

    // R2 init never asserts
    do_run(3, 255, 3, 0, 255, 2, 1'b0, 1'b0);
    chk(fail_code_o == 3'd1, "R2", "init-assert timeout code", fail_code_o, 1);
    chk(last_plow == IAT, "R2", "program width at timeout", last_plow, IAT);
    chk(ncsf == 0, "R2", "no select after timeout", ncsf, 0);

    // R3 init never releases
    do_run(3, 2, 255, 0, 255, 2, 1'b0, 1'b0);
    chk(fail_code_o == 3'd2, "R3", "init-release timeout code", fail_code_o, 2);
    chk(ncsf == 0, "R3", "no select", ncsf, 0);
    chk(!pass_o, "R3", "no pass", pass_o, 0);

    // R6 CRC error after byte 3 of 5
    do_run(5, 2, 3, 1, 3, 2, 1'b0, 1'b0);
    chk(fail_code_o == 3'd3, "R6", "crc code", fail_code_o, 3);
    chk(npulse == 3, "R6", "pulses before abort", npulse, 3);
    chk(ncap == 3, "R6", "bytes before abort", ncap, 3);
    chk(t_wr == t_cs, "R10", "strobes released together", t_wr - t_cs, 0);
    chk(cs_n_o && write_n_o && prog_n_o, "R10", "pins released", {cs_n_o, write_n_o}, 3);

    // R6 CRC error after first byte with gappy stream
    do_run(4, 2, 3, 0, 1, 2, 1'b1, 1'b0);
    chk(fail_code_o == 3'd3, "R6", "crc code first byte", fail_code_o, 3);
    chk(npulse == 1, "R6", "single pulse", npulse, 1);

    // R7 busy stuck
    do_run(4, 2, 3, 255, 255, 2, 1'b0, 1'b0);
    chk(fail_code_o == 3'd4, "R7", "busy timeout code", fail_code_o, 4);
    chk(npulse == 1, "R7", "pulses before busy abort", npulse, 1);
    chk(t_wr == t_cs, "R10", "strobes released together busy", t_wr - t_cs, 0);

    // R9 done never arrives
    do_run(4, 2, 3, 0, 255, 255, 1'b0, 1'b0);
    chk(fail_code_o == 3'd5, "R9", "done timeout code", fail_code_o, 5);
    chk(ncap == 4, "R9", "all bytes sent", ncap, 4);
    chk(!pass_o, "R9", "no pass on done timeout", pass_o, 0);
    repeat (10) @(negedge clk);
    chk(fail_code_o == 3'd5, "R10", "code sticky in idle", fail_code_o, 5);

    // R10 next start clears, R11 mid-run start ignored
    do_run(4, 2, 3, 1, 255, 2, 1'b0, 1'b1);
    chk_success(4, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R9 global watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule